// File: doc/BRIEF.md
# Timer compare output control unit

This block turns compare-match strobes into four timer output pins. Each pin has a small flip-flop that holds an "active" flag. Single-cycle events set, clear or toggle that flag. A 4-bit field per channel selects which events do this. The field also chooses the output polarity and can force the pin to a fixed level. The counters that produce the strobes and the compare registers are outside the block.

The control word is 16 bits and resets to zero. Software can write it as a whole word, one byte at a time, or one bit at a time. Every strobe is one clock wide. A flag changes on the clock edge at which its strobe is high. The pins follow the flags and the control word combinationally, so a change shows on the pin in the cycle after that edge.

Top module: `tcu_top`

## Requirements
- R1: After reset the control word reads 0x0000, all four flags are inactive and all four pins are low.
- R2: Channel c (0..3) owns control bits [4c+3:4c]. Within that field, bit 3 is force-enable, bit 2 is active-low select and bits 1:0 are the mode. A word write with byte enables updates only the enabled bytes (enable bit b covers bits [8b+7:8b]). A single-bit write sets bit `bit_sel_i` to `bit_val_i` and takes precedence over a byte write to the same bit in the same cycle.
- R3: When force-enable is 0, the pin equals the flag XOR the active-low select bit. A polarity change shows on the pin in the cycle after the write and does not alter the flag.
- R4: When force-enable is 1, the pin equals the active-low select bit (low for 0, high for 1), whatever the flag holds.
- R5: Mode 00 inverts the flag on each match of the channel's own strobe. Both counter-clear strobes have no effect on it.
- R6: Mode 01 sets the flag on the channel's own match and clears it on `clr0_i`. `clr1_i` has no effect.
- R7: Mode 10 sets the flag on the channel's own match and clears it on `clr1_i`. `clr0_i` has no effect.
- R8: Mode 11 sets the flag on the channel's own match and clears it on the match of the next channel. The next channel of channel 3 is channel 0.
- R9: If a set or toggle event and a clear event reach a channel in the same cycle, the set or toggle event decides the flag.
- R10: A change of mode or force-enable leaves the stored flag unchanged.
- R11: A set of an active flag, or a clear of an inactive flag, leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word write strobe |
| byte_en_i | input | 2 | Byte lane enables for the word write |
| wdata_i | input | 16 | Write data |
| bit_we_i | input | 1 | Single-bit write strobe |
| bit_sel_i | input | 4 | Index of the bit to write |
| bit_val_i | input | 1 | Value for the single-bit write |
| match_i | input | 4 | Compare-match strobes, one per channel |
| clr0_i | input | 1 | Clear strobe of base counter 0 |
| clr1_i | input | 1 | Clear strobe of base counter 1 |
| ctrl_o | output | 16 | Current control word |
| pin_o | output | 4 | Timer output pins |

## Verification
The set or toggle path and the clear path can both reach one flag in the same edge. The bench provokes this in several ways: a channel's own strobe together with a base-counter clear, and, in the pairing mode, all four match strobes at once, so every channel is set by its own strobe and cleared by its neighbour's. A flag that ends inactive means the clear path won, and the bench reports that. Random cycles then mix strobes, clears and register writes. Each result is checked against a bench model that updates the flags with the control word held before the write.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_CLR0   = 2'b01,
    MODE_CLR1   = 2'b10,
    MODE_PAIR   = 2'b11
  } tcu_mode_e;

  typedef struct packed {
    logic      force_en;
    logic      act_low;
    tcu_mode_e mode;
  } tcu_field_t;

  localparam int unsigned FIELD_W = $bits(tcu_field_t);
endpackage

// File: rtl/tcu_ctrl_reg.sv
module tcu_ctrl_reg #(
  parameter int unsigned REG_W = 16,
  localparam int unsigned NB  = REG_W / 8,
  localparam int unsigned SEL_W = $clog2(REG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [NB-1:0]    byte_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             bit_we_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             bit_val_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    for (int b = 0; b < NB; b++)
      if (wr_en_i && byte_en_i[b]) nxt[b*8 +: 8] = wdata_i[b*8 +: 8];
    if (bit_we_i) nxt[bit_sel_i] = bit_val_i;  // bit write overrides lane write
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= nxt;

  assign q_o = q;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !bit_we_i |=> $stable(q));
  p_bit_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_we_i |=> q[$past(bit_sel_i)] == $past(bit_val_i));
endmodule

// File: rtl/tcu_chan.sv
module tcu_chan
  import tcu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  tcu_field_t field_i,
  input  logic       own_match_i,
  input  logic       next_match_i,
  input  logic       clr0_i,
  input  logic       clr1_i,
  output logic       pin_o
);
  logic flag_q;
  logic rst_ev;

  always_comb begin
    unique case (field_i.mode)
      MODE_TOGGLE: rst_ev = 1'b0;
      MODE_CLR0:   rst_ev = clr0_i;
      MODE_CLR1:   rst_ev = clr1_i;
      default:     rst_ev = next_match_i;
    endcase
  end

  // set/toggle has priority over reset
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           flag_q <= 1'b0;
    else if (own_match_i)  flag_q <= (field_i.mode == MODE_TOGGLE) ? ~flag_q : 1'b1;
    else if (rst_ev)       flag_q <= 1'b0;

  assign pin_o = field_i.force_en ? field_i.act_low : (flag_q ^ field_i.act_low);

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_match_i && field_i.mode == MODE_TOGGLE |=> flag_q != $past(flag_q));
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_match_i && field_i.mode != MODE_TOGGLE |=> flag_q);
  p_clr0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_match_i && field_i.mode == MODE_CLR0 && clr0_i |=> !flag_q);
  p_clr1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_match_i && field_i.mode == MODE_CLR1 && clr1_i |=> !flag_q);
  p_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_match_i && field_i.mode == MODE_PAIR && next_match_i |=> !flag_q);
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_match_i && !next_match_i && !clr0_i && !clr1_i |=> $stable(flag_q));
  p_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_i.force_en |-> pin_o == field_i.act_low);
endmodule

// File: rtl/tcu_top.sv
module tcu_top
  import tcu_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned REG_W = NUM_CH * FIELD_W,
  localparam int unsigned NB    = REG_W / 8,
  localparam int unsigned SEL_W = $clog2(REG_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NB-1:0]     byte_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              bit_we_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  logic              bit_val_i,
  input  logic [NUM_CH-1:0] match_i,
  input  logic              clr0_i,
  input  logic              clr1_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [NUM_CH-1:0] pin_o
);
  logic [REG_W-1:0] ctrl_q;

  tcu_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .byte_en_i, .wdata_i,
    .bit_we_i, .bit_sel_i, .bit_val_i, .q_o(ctrl_q)
  );

  assign ctrl_o = ctrl_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tcu_field_t fld;
    assign fld = tcu_field_t'(ctrl_q[c*FIELD_W +: FIELD_W]);
    tcu_chan u_ch (
      .clk_i, .rst_ni,
      .field_i      (fld),
      .own_match_i  (match_i[c]),
      .next_match_i (match_i[(c+1) % NUM_CH]),  // wraps last to first
      .clr0_i, .clr1_i,
      .pin_o        (pin_o[c])
    );
  end
endmodule

// File: tb/tcu_top_test.sv
`timescale 1ns/1ps
module tcu_top_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, bit_we = 0, bit_val = 0, clr0 = 0, clr1 = 0;
  logic [1:0] be = 0;
  logic [15:0] wdata = 0;
  logic [3:0] bit_sel = 0, match = 0;
  wire  [15:0] ctrl;
  wire  [3:0] pin;
  logic [15:0] m_ctrl = 0;
  logic [3:0] m_flag = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tcu_top uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .byte_en_i(be), .wdata_i(wdata),
    .bit_we_i(bit_we), .bit_sel_i(bit_sel), .bit_val_i(bit_val),
    .match_i(match), .clr0_i(clr0), .clr1_i(clr1), .ctrl_o(ctrl), .pin_o(pin)
  );

  function automatic logic [3:0] next_flags(logic [15:0] cw, logic [3:0] fl,
                                            logic [3:0] m, logic c0, logic c1);
    logic [3:0] r;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] md;
      logic rs;
      md = cw[4*c +: 2];
      rs = (md == 2'd1) ? c0 : (md == 2'd2) ? c1 : (md == 2'd3) ? m[(c+1)%4] : 1'b0;
      if (m[c])    r[c] = (md == 2'd0) ? ~fl[c] : 1'b1;
      else if (rs) r[c] = 1'b0;
      else         r[c] = fl[c];
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_pins(logic [15:0] cw, logic [3:0] fl);
    logic [3:0] r;
    for (int c = 0; c < 4; c++)
      r[c] = cw[4*c+3] ? cw[4*c+2] : (fl[c] ^ cw[4*c+2]);
    return r;
  endfunction

  task automatic check(string req);
    logic [3:0] ep;
    ep = exp_pins(m_ctrl, m_flag);
    checks++;
    if (pin !== ep || ctrl !== m_ctrl) begin
      fails++;
      $display("FAIL %s: pin=%b ctrl=%h expected pin=%b ctrl=%h", req, pin, ctrl, ep, m_ctrl);
    end
  endtask

  // inputs are set at a negedge; model advances with pre-write control word
  task automatic tick(string req);
    logic [15:0] nc;
    m_flag = next_flags(m_ctrl, m_flag, match, clr0, clr1);
    nc = m_ctrl;
    if (wr_en && be[0]) nc[7:0]  = wdata[7:0];
    if (wr_en && be[1]) nc[15:8] = wdata[15:8];
    if (bit_we) nc[bit_sel] = bit_val;
    m_ctrl = nc;
    @(negedge clk);
    check(req);
    wr_en = 0; bit_we = 0; match = 0; clr0 = 0; clr1 = 0;
  endtask

  task automatic wr_word(logic [15:0] d, logic [1:0] b, string req);
    wr_en = 1; be = b; wdata = d; tick(req);
  endtask

  task automatic wr_bit(int idx, logic v, string req);
    bit_we = 1; bit_sel = 4'(idx); bit_val = v; tick(req);
  endtask

  task automatic expect_pins(logic [3:0] e, string req);
    checks++;
    if (pin !== e) begin
      fails++;
      $display("FAIL %s: pin=%b expected %b", req, pin, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state");
    expect_pins(4'b0000, "R1 pins low");
    rst_n = 1;
    @(negedge clk);

    // R5: toggle mode, clears ignored
    match = 4'b0001; tick("R5 toggle on");
    expect_pins(4'b0001, "R5 toggled high");
    clr0 = 1; clr1 = 1; tick("R5 clears ignored");
    expect_pins(4'b0001, "R5 still high");
    match = 4'b0001; tick("R5 toggle off");
    expect_pins(4'b0000, "R5 toggled low");

    // R2: word write: ch0 mode01, ch1 mode10, ch2/ch3 mode11
    wr_word(16'h3321, 2'b11, "R2 word write");
    // R9: every channel set and cleared in the same cycle
    match = 4'b1111; clr0 = 1; clr1 = 1; tick("R9 set beats reset");
    expect_pins(4'b1111, "R9 all active");
    clr1 = 1; tick("R7 clr1 clears ch1");
    expect_pins(4'b1101, "R7 ch1 cleared");
    clr0 = 1; tick("R6 clr0 clears ch0");
    expect_pins(4'b1100, "R6 ch0 cleared");
    match = 4'b0001; tick("R8 wrap clears ch3");
    expect_pins(4'b0101, "R8 wrap");
    match = 4'b1000; tick("R8 ch3 match clears ch2");
    expect_pins(4'b1001, "R8 next clears");
    match = 4'b1001; tick("R11 set of active flag");
    expect_pins(4'b1001, "R11 unchanged");
    clr1 = 1; tick("R11 clear of inactive ch1");
    expect_pins(4'b1001, "R11 inactive stays");

    // R3: polarity flip on ch0 via bit write
    wr_bit(2, 1'b1, "R3 active low ch0");
    expect_pins(4'b1000, "R3 inverted");
    wr_bit(2, 1'b0, "R3 restore");
    // R4: force ch0 low then high
    wr_word(16'h0029, 2'b01, "R4 force low");
    expect_pins(4'b1000, "R4 forced low");
    wr_word(16'h002D, 2'b01, "R4 force high");
    expect_pins(4'b1001, "R4 forced high");
    // R10: drop force and change mode, flag kept
    wr_word(16'h0020, 2'b01, "R10 mode to toggle");
    expect_pins(4'b1001, "R10 flag kept");
    wr_word(16'hFF00, 2'b10, "R2 upper byte only");
    wr_bit(15, 1'b0, "R2 bit write");
    // bit write and byte write to the same bit
    wr_en = 1; be = 2'b11; wdata = 16'h0000; bit_we = 1; bit_sel = 4'd7; bit_val = 1;
    tick("R2 bit wins over byte");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      match = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
      clr0 = ($urandom_range(0, 3) == 0);
      clr1 = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1; be = 2'($urandom_range(0, 3)); wdata = 16'($urandom);
      end
      if ($urandom_range(0, 9) == 0) begin
        bit_we = 1; bit_sel = 4'($urandom_range(0, 15)); bit_val = 1'($urandom);
      end
      tick("R3/R4/R5/R6/R7/R8/R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end
endmodule